// File: doc/BRIEF.md
# Load-Use Stall Controller

This block lives in the decode stage of a five-stage in-order pipeline. It compares the source registers of the instruction now being decoded with the destination of a load that sits one stage ahead, in execute. A load's value first exists at the end of the memory stage. A dependent instruction directly behind the load would need that value one cycle before it can be forwarded. When this block finds that dependency, it freezes the program counter and the fetch/decode register for a cycle. It also makes the pipeline replace the control bundle entering the decode/execute register with zeros, which turns that slot into a bubble.

Three conditions never cause a stall: a load that targets register zero, the data operand of a store, and any dependency that is two or more instructions away. A branch that resolves in decode needs its operands earlier than an ALU instruction does. A load-use match on a branch therefore holds the front end for a configurable number of cycles, two by default. A small counter carries the stall through the extra cycles after the load has left execute.

Top module: `load_use_stall`

## Requirements
- R1: Synchronous reset (`rst` high at a rising edge) clears any pending extra branch-stall cycle. In the first cycle after reset, with no load in execute, `pcWriteEn`, `ifIdWriteEn` and `ctrlPassSel` all read 1.
- R2: When `exIsLoad` is 1, `exDestReg` is nonzero, and `exDestReg` equals `idSrcA`, or equals `idSrcB` for a non-store, the block stalls in the same cycle. A match on one source is enough.
- R3: A load whose `exDestReg` is 0 never starts a stall, whatever the source registers are.
- R4: When `exIsLoad` is 0, no new stall starts, even if the register numbers match.
- R5: The three outputs always carry the same value: 1 means run normally, and 0 means hold the PC, hold IF/ID and force the ID/EX control to zero.
- R6: For a store (`idIsStore` = 1), a match on `idSrcB` (the store data) alone does not stall. A match on `idSrcA` (the address base) does stall.
- R7: A stall that starts with `idIsBranch` = 1 lasts BRANCH_STALL_CYCLES consecutive cycles (default 2), whatever the inputs do in the later cycles.
- R8: A stall that starts with `idIsBranch` = 0 lasts one cycle. If the next cycle brings no new hazard, the outputs return to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| exIsLoad | input | 1 | The instruction in the ID/EX register reads data memory |
| exDestReg | input | REG_ADDR_W | Destination register of the instruction in ID/EX |
| idSrcA | input | REG_ADDR_W | First source register of the decoding instruction (address base for stores) |
| idSrcB | input | REG_ADDR_W | Second source register of the decoding instruction (store data for stores) |
| idIsStore | input | 1 | The decoding instruction is a store |
| idIsBranch | input | 1 | The decoding instruction is a branch resolved in decode |
| pcWriteEn | output | 1 | 1 lets the PC advance; 0 holds it |
| ifIdWriteEn | output | 1 | 1 lets IF/ID load; 0 holds it |
| ctrlPassSel | output | 1 | 1 passes decoded control to ID/EX; 0 forces it to zero |

## Verification
The only internal state is the branch-extension counter, and a fault in it shows at the ports within one cycle. A counter that is not loaded cuts a branch stall short: the outputs rise in the second cycle. A counter that fails to clear, on reset or otherwise, keeps the outputs low in a cycle that has no hazard. Faults in the comparators show in the same cycle as the input pattern: a stall that is missing or spurious, a store-data match that stalls, or a register-zero load that stalls. The stimulus mixes random traffic, with register numbers drawn from a small pool, and directed sequences for each of these cases.

// File: rtl/load_use_stall_pkg.sv
package load_use_stall_pkg;

  // Result of the register comparison, produced by the datapath.
  typedef struct packed {
    logic loadUse;    // a load in execute feeds a source that is needed now
    logic branchUse;  // the consumer is a branch resolved in decode
  } hazardHitT;

  // Strobes from the control to the output stage.
  typedef struct packed {
    logic freezeFront;   // hold PC and IF/ID
    logic insertBubble;  // zero the ID/EX control bundle
  } stallStrobeT;

endpackage

// File: rtl/load_use_stall_dp.sv
module load_use_stall_dp
  import load_use_stall_pkg::*;
#(
  parameter int REG_ADDR_W = 5,
  parameter int NUM_SRC    = 2,
  // Bit i set: source i is store data and is exempt for stores.
  parameter logic [NUM_SRC-1:0] STORE_EXEMPT = 2'b10
) (
  input  logic                             exIsLoad,
  input  logic [REG_ADDR_W-1:0]            exDestReg,
  input  logic [NUM_SRC-1:0][REG_ADDR_W-1:0] idSrc,
  input  logic                             idIsStore,
  input  logic                             idIsBranch,
  output hazardHitT                        hit
);

  localparam logic [REG_ADDR_W-1:0] ZERO_REG = '0;

  logic destWritable;
  logic [NUM_SRC-1:0] srcMatch;

  // Register zero is hardwired, so a load into it produces nothing to wait for.
  assign destWritable = exIsLoad && (exDestReg != ZERO_REG);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    if (STORE_EXEMPT[s]) begin : g_exempt
      // Store data is consumed in MEM and can be forwarded there.
      assign srcMatch[s] = (idSrc[s] == exDestReg) && !idIsStore;
    end else begin : g_plain
      assign srcMatch[s] = (idSrc[s] == exDestReg);
    end
  end

  always_comb begin
    hit.loadUse   = destWritable && (|srcMatch);
    hit.branchUse = idIsBranch;
  end

endmodule

// File: rtl/load_use_stall_ctrl.sv
module load_use_stall_ctrl
  import load_use_stall_pkg::*;
#(
  parameter int BRANCH_STALL_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  hazardHitT   hit,
  output stallStrobeT strobe
);

  localparam int EXTRA_CYCLES = (BRANCH_STALL_CYCLES > 1) ? BRANCH_STALL_CYCLES - 1 : 0;
  localparam int CNT_W        = (EXTRA_CYCLES > 1) ? $clog2(EXTRA_CYCLES + 1) : 1;

  logic holdActive;

  if (EXTRA_CYCLES > 0) begin : g_extend
    logic [CNT_W-1:0] holdCnt;

    always_ff @(posedge clk) begin
      if (rst) begin
        holdCnt <= '0;
      end else if (holdCnt != '0) begin
        holdCnt <= holdCnt - 1'b1;
      end else if (hit.loadUse && hit.branchUse) begin
        holdCnt <= CNT_W'(EXTRA_CYCLES);
      end
    end

    assign holdActive = (holdCnt != '0);
  end else begin : g_single
    assign holdActive = 1'b0;
  end

  always_comb begin
    strobe.freezeFront  = hit.loadUse || holdActive;
    strobe.insertBubble = hit.loadUse || holdActive;
  end

endmodule

// File: rtl/load_use_stall.sv
module load_use_stall
  import load_use_stall_pkg::*;
#(
  parameter int REG_ADDR_W          = 5,
  parameter int BRANCH_STALL_CYCLES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  exIsLoad,
  input  logic [REG_ADDR_W-1:0] exDestReg,
  input  logic [REG_ADDR_W-1:0] idSrcA,
  input  logic [REG_ADDR_W-1:0] idSrcB,
  input  logic                  idIsStore,
  input  logic                  idIsBranch,
  output logic                  pcWriteEn,
  output logic                  ifIdWriteEn,
  output logic                  ctrlPassSel
);

  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_ADDR_W-1:0] srcBus;
  hazardHitT   hit;
  stallStrobeT strobe;

  assign srcBus[0] = idSrcA;
  assign srcBus[1] = idSrcB;

  load_use_stall_dp #(
    .REG_ADDR_W   (REG_ADDR_W),
    .NUM_SRC      (NUM_SRC),
    .STORE_EXEMPT (2'b10)
  ) dp_i (
    .exIsLoad   (exIsLoad),
    .exDestReg  (exDestReg),
    .idSrc      (srcBus),
    .idIsStore  (idIsStore),
    .idIsBranch (idIsBranch),
    .hit        (hit)
  );

  load_use_stall_ctrl #(
    .BRANCH_STALL_CYCLES (BRANCH_STALL_CYCLES)
  ) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .hit    (hit),
    .strobe (strobe)
  );

  assign pcWriteEn   = !strobe.freezeFront;
  assign ifIdWriteEn = !strobe.freezeFront;
  assign ctrlPassSel = !strobe.insertBubble;

endmodule

// File: rtl/load_use_stall_chk.sv
module load_use_stall_chk #(
  parameter int REG_ADDR_W = 5
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  exIsLoad,
  input logic [REG_ADDR_W-1:0] exDestReg,
  input logic [REG_ADDR_W-1:0] idSrcA,
  input logic [REG_ADDR_W-1:0] idSrcB,
  input logic                  idIsStore,
  input logic                  idIsBranch,
  input logic                  pcWriteEn,
  input logic                  ifIdWriteEn,
  input logic                  ctrlPassSel
);

  // R1
  reset_release_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !exIsLoad) |-> pcWriteEn);

  // R2
  src_a_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (exIsLoad && exDestReg != '0 && idSrcA == exDestReg) |-> !pcWriteEn);

  // R3
  zero_dest_chk: assert property (@(posedge clk) disable iff (rst)
    (exDestReg == '0 && $past(pcWriteEn)) |-> pcWriteEn);

  // R4
  no_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!exIsLoad && $past(pcWriteEn)) |-> pcWriteEn);

  // R5
  outputs_agree_chk: assert property (@(posedge clk) disable iff (rst)
    (pcWriteEn == ifIdWriteEn) && (ifIdWriteEn == ctrlPassSel));

  // R6
  store_data_exempt_chk: assert property (@(posedge clk) disable iff (rst)
    (idIsStore && idSrcA != exDestReg && $past(pcWriteEn)) |-> pcWriteEn);

  // R7
  branch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pcWriteEn && idIsBranch && $past(pcWriteEn)) |=> !pcWriteEn);

  // R8
  single_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    (!pcWriteEn && !idIsBranch && $past(pcWriteEn)) |=> (exIsLoad || pcWriteEn));

endmodule

bind load_use_stall load_use_stall_chk #(.REG_ADDR_W(REG_ADDR_W)) chk_i (.*);

// File: tb/load_use_stall_tb.sv
module load_use_stall_tb_top;

  localparam int REG_ADDR_W   = 5;
  localparam int BRANCH_STALL = 2;
  localparam int EXTRA        = BRANCH_STALL - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic exIsLoad = 1'b0;
  logic [REG_ADDR_W-1:0] exDestReg = '0;
  logic [REG_ADDR_W-1:0] idSrcA = '0;
  logic [REG_ADDR_W-1:0] idSrcB = '0;
  logic idIsStore = 1'b0;
  logic idIsBranch = 1'b0;
  logic pcWriteEn, ifIdWriteEn, ctrlPassSel;

  int checks = 0;
  int fails  = 0;
  int pend   = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  load_use_stall #(.REG_ADDR_W(REG_ADDR_W), .BRANCH_STALL_CYCLES(BRANCH_STALL)) dut_i (
    .clk(clk), .rst(rst), .exIsLoad(exIsLoad), .exDestReg(exDestReg),
    .idSrcA(idSrcA), .idSrcB(idSrcB), .idIsStore(idIsStore), .idIsBranch(idIsBranch),
    .pcWriteEn(pcWriteEn), .ifIdWriteEn(ifIdWriteEn), .ctrlPassSel(ctrlPassSel)
  );

  function automatic bit expHazard(bit ld, logic [REG_ADDR_W-1:0] d,
                                   logic [REG_ADDR_W-1:0] a, logic [REG_ADDR_W-1:0] b, bit st);
    if (!ld || d == '0) return 1'b0;
    if (a == d) return 1'b1;
    if (b == d && !st) return 1'b1;
    return 1'b0;
  endfunction

  task automatic step(bit r, bit ld, logic [REG_ADDR_W-1:0] d,
                      logic [REG_ADDR_W-1:0] a, logic [REG_ADDR_W-1:0] b,
                      bit st, bit br, string tag);
    bit hz;
    bit expRun;
    @(negedge clk);
    rst = r; exIsLoad = ld; exDestReg = d; idSrcA = a; idSrcB = b;
    idIsStore = st; idIsBranch = br;
    #5;
    hz = expHazard(ld, d, a, b, st);
    expRun = !(hz || pend != 0);
    checks++;
    if (pcWriteEn !== expRun || ifIdWriteEn !== expRun || ctrlPassSel !== expRun) begin
      fails++;
      $display("FAIL %s: pc=%b ifid=%b ctl=%b expected all %b",
               tag, pcWriteEn, ifIdWriteEn, ctrlPassSel, expRun);
    end
    if (r) pend = 0;
    else if (pend > 0) pend--;
    else if (hz && br) pend = EXTRA;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    step(1, 0, 0, 0, 0, 0, 0, "R1 during reset");
    step(1, 0, 0, 0, 0, 0, 0, "R1 during reset");
    step(0, 0, 0, 0, 0, 0, 0, "R1 after reset idle");
    // R2 load then ALU consumer on each source
    step(0, 1, 5'd2, 5'd2, 5'd5, 0, 0, "R2 srcA match");
    step(0, 0, 5'd0, 5'd2, 5'd5, 0, 0, "R8 consumer proceeds after one bubble");
    step(0, 1, 5'd7, 5'd1, 5'd7, 0, 0, "R2 srcB match");
    step(0, 1, 5'd7, 5'd1, 5'd3, 0, 0, "R2 no match no stall");
    // R3 register zero guard
    step(0, 1, 5'd0, 5'd0, 5'd0, 0, 0, "R3 zero dest");
    step(0, 1, 5'd0, 5'd0, 5'd0, 0, 1, "R3 zero dest branch");
    // R4 no load in execute
    step(0, 0, 5'd9, 5'd9, 5'd9, 0, 0, "R4 alu producer");
    step(0, 0, 5'd9, 5'd9, 5'd9, 0, 1, "R4 alu producer branch");
    // R6 stores
    step(0, 1, 5'd4, 5'd6, 5'd4, 1, 0, "R6 store data only");
    step(0, 1, 5'd4, 5'd4, 5'd8, 1, 0, "R6 store base");
    step(0, 0, 5'd0, 5'd4, 5'd8, 1, 0, "R8 store proceeds");
    // R7 branch held two cycles, second cycle with bubble inputs
    step(0, 1, 5'd3, 5'd3, 5'd1, 0, 1, "R7 branch first cycle");
    step(0, 0, 5'd0, 5'd3, 5'd1, 0, 1, "R7 branch second cycle");
    step(0, 0, 5'd0, 5'd3, 5'd1, 0, 1, "R7 branch released");
    // R7 second cycle held even with unrelated load
    step(0, 1, 5'd3, 5'd1, 5'd3, 0, 1, "R7 branch srcB first");
    step(0, 1, 5'd6, 5'd1, 5'd2, 0, 0, "R7 held despite new inputs");
    step(0, 0, 5'd0, 5'd1, 5'd2, 0, 0, "R7 after hold");
    // R1 reset clears a pending branch hold
    step(0, 1, 5'd5, 5'd5, 5'd0, 0, 1, "R1 branch before reset");
    step(1, 0, 5'd0, 5'd0, 5'd0, 0, 0, "R1 reset cycle still holding");
    step(0, 0, 5'd0, 5'd5, 5'd0, 0, 1, "R1 hold cleared by reset");
    // Random traffic with a small register pool
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 2000; i++) begin
      bit ld, st, br;
      logic [REG_ADDR_W-1:0] d, a, b;
      ld = ($urandom % 2) == 0;
      br = ($urandom % 4) == 0;
      st = !br && (($urandom % 3) == 0);
      d  = REG_ADDR_W'($urandom % 4);
      a  = REG_ADDR_W'($urandom % 4);
      b  = REG_ADDR_W'($urandom % 4);
      step(($urandom % 97) == 0, ld, d, a, b, st, br, "R2 R3 R4 R5 R6 R7 R8 random");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule